// File: doc/BRIEF.md
# Audio Oversampling Clock Generator

This block turns one audio base clock into the three clocks an audio serial port needs. The first is a master clock for an external converter. The second is a serial bit clock. The third is a frame clock that marks left and right samples. The base clock runs at 512 times the sample rate when the 384-family select is clear, and at 384 times the sample rate when it is set. Sample rates from 8 kHz to 192 kHz are all handled the same way, because every ratio is counted in base-clock cycles.

All three outputs are registered levels with a 50% duty cycle, and they change only on base-clock rising edges. Each clock comes with a strobe. The strobe is high for exactly one base cycle, in the cycle where that clock's high phase begins, so downstream logic that runs on the base clock can use it as a clock enable.

No data moves through this block. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure to honour.

Top module: `aosc_clkgen`

## Requirements
- R1: While reset is asserted, or while `run_i` is low or `gate_i` is high, all six clock and strobe outputs are low. The first base edge that samples `run_i`=1 and `gate_i`=0 restarts the sample at phase 0, with the master, bit and frame clocks high and all three strobes high. The first edge that samples a stop drives every output low.
- R2: The master clock has a period of 2^code base cycles, where code is `mul_code_i`. It is high for the first half of each period, and `mclk_stb_o` pulses when the high half begins. Code 0 holds both `mclk_o` and `mclk_stb_o` high. In the 512 family codes 0 to 4 give 512, 256, 128, 64 and 32 fs. In the 384 family codes 0 to 3 give 384, 192, 96 and 48 fs.
- R3: The bit clock period is 8 base cycles in the 512 family (64 fs). In the 384 family it is 6 base cycles (64 fs) with `bit48_i`=0, and 8 base cycles (48 fs) with `bit48_i`=1. It is high for the first half of each period, and `bclk_stb_o` pulses when the high half begins.
- R4: The frame clock is high for the first half of each sample (left) and low for the second half (right). A sample is 512 base cycles in the 512 family and 384 in the 384 family, which is 32 or 24 bit clocks per half. `fclk_stb_o` pulses at the start of each sample, in the same cycle as `bclk_stb_o` and, when the master clock is legal, `mclk_stb_o`.
- R5: A multiplier code above the family limit is illegal: code 4 or above in the 384 family, or 5 or above in the 512 family. With an illegal code, `mclk_o` and `mclk_stb_o` stay low and `cfg_err_o` is high, while the bit and frame clocks keep running.
- R6: `bit48_i`=1 in the 512 family is illegal because 512 is not a multiple of 48. In that case the bit clock, the frame clock and their strobes stay low and `cfg_err_o` is high, while the master clock keeps running.
- R7: A change to `fam384_i`, `mul_code_i` or `bit48_i` while running takes effect at the next sample start. Values present at the base edge that ends a sample's last cycle apply from the next sample on. A change made after that edge waits one more sample.
- R8: While the block is stopped, the settings are reloaded every base cycle, and `cfg_err_o` shows the legality of the settings sampled at the most recent edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Audio base clock, 512 or 384 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run request |
| gate_i | input | 1 | Clock gate; high stops all outputs |
| fam384_i | input | 1 | Family select: 0 = 512 fs base, 1 = 384 fs base |
| mul_code_i | input | 3 | Master-clock divide code, period 2^code base cycles |
| bit48_i | input | 1 | Bit clock at 48 fs instead of 64 fs |
| mclk_o | output | 1 | Master clock level |
| mclk_stb_o | output | 1 | One-cycle strobe at the start of a master-clock high phase |
| bclk_o | output | 1 | Bit clock level |
| bclk_stb_o | output | 1 | One-cycle strobe at the start of a bit-clock high phase |
| fclk_o | output | 1 | Frame clock level, high for the left half of the sample |
| fclk_stb_o | output | 1 | One-cycle strobe at each sample start |
| cfg_err_o | output | 1 | Active settings are illegal |

## Verification
Two functions can land on the same base edge: reloading the settings and wrapping the sample counter. The frame that finishes on that edge must still be shaped by the old settings, and the next one by the new settings. The bench provokes this by changing the settings once in the second-to-last cycle of a sample, once in the last cycle, and once mid-sample. Its cycle-by-cycle model moves to the new settings only from the value captured at the wrapping edge. The bench then compares every level, every strobe and the error flag in every cycle. This shows whether a change was applied one sample too early or one sample too late.

// File: rtl/aosc_pkg.sv
package aosc_pkg;
  localparam int CODE_W = 3;
  localparam int NCLK   = 3;
  localparam int IDX_M  = 0;
  localparam int IDX_B  = 1;
  localparam int IDX_F  = 2;

  typedef struct packed {
    logic              fam384;
    logic [CODE_W-1:0] code;
    logic              bit48;
  } aosc_cfg_t;
endpackage

// File: rtl/aosc_cfg_hold.sv
module aosc_cfg_hold
  import aosc_pkg::*;
#(
  parameter int SPAN_HI = 512,
  parameter int SPAN_LO = 384,
  parameter int BITS_HI = 64,
  parameter int BITS_LO = 48,
  parameter int MAXC_HI = 4,
  parameter int MAXC_LO = 3,
  parameter int PH_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              frame_end,
  input  aosc_cfg_t         live,
  output logic [CODE_W-1:0] code_q,
  output logic [PH_W:0]     span,
  output logic [PH_W-1:0]   bper,
  output logic              mbad,
  output logic              bbad
);
  localparam logic [PH_W:0]     SPN_H = (PH_W+1)'(SPAN_HI);
  localparam logic [PH_W:0]     SPN_L = (PH_W+1)'(SPAN_LO);
  localparam logic [PH_W-1:0]   BP_H64 = PH_W'(SPAN_HI / BITS_HI);
  localparam logic [PH_W-1:0]   BP_H48 = PH_W'(SPAN_HI / BITS_LO);
  localparam logic [PH_W-1:0]   BP_L64 = PH_W'(SPAN_LO / BITS_HI);
  localparam logic [PH_W-1:0]   BP_L48 = PH_W'(SPAN_LO / BITS_LO);
  localparam bit H64_OK = (SPAN_HI % BITS_HI) == 0;
  localparam bit H48_OK = (SPAN_HI % BITS_LO) == 0;
  localparam bit L64_OK = (SPAN_LO % BITS_HI) == 0;
  localparam bit L48_OK = (SPAN_LO % BITS_LO) == 0;
  localparam logic [CODE_W-1:0] MC_H = CODE_W'(MAXC_HI);
  localparam logic [CODE_W-1:0] MC_L = CODE_W'(MAXC_LO);

  aosc_cfg_t cur;

  // settings track the pins while stopped, and reload only at a sample wrap while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cur <= '0;
    else if (!go || frame_end) cur <= live;
  end

  always_comb begin
    code_q = cur.code;
    span   = cur.fam384 ? SPN_L : SPN_H;
    if (cur.fam384) begin
      bper = cur.bit48 ? BP_L48 : BP_L64;
      bbad = cur.bit48 ? !L48_OK : !L64_OK;
      mbad = cur.code > MC_L;
    end else begin
      bper = cur.bit48 ? BP_H48 : BP_H64;
      bbad = cur.bit48 ? !H48_OK : !H64_OK;
      mbad = cur.code > MC_H;
    end
  end
endmodule

// File: rtl/aosc_phase_ctr.sv
module aosc_phase_ctr #(
  parameter int PH_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [PH_W:0]   span,
  input  logic [PH_W-1:0] bper,
  output logic [PH_W-1:0] phase,
  output logic [PH_W-1:0] bcnt,
  output logic            frame_end
);
  assign frame_end = go && ({1'b0, phase} == span - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      bcnt  <= '0;
    end else if (!go) begin
      phase <= '0;
      bcnt  <= '0;
    end else begin
      phase <= frame_end ? '0 : phase + 1'b1;
      bcnt  <= (frame_end || bcnt == bper - 1'b1) ? '0 : bcnt + 1'b1;
    end
  end
endmodule

// File: rtl/aosc_clk_shape.sv
module aosc_clk_shape (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic ok,
  input  logic lvl,
  input  logic stb,
  output logic ck_o,
  output logic stb_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_o  <= 1'b0;
      stb_o <= 1'b0;
    end else begin
      ck_o  <= go & ok & lvl;
      stb_o <= go & ok & stb;
    end
  end
endmodule

// File: rtl/aosc_clkgen.sv
module aosc_clkgen
  import aosc_pkg::*;
#(
  parameter int SPAN_HI = 512,
  parameter int SPAN_LO = 384,
  parameter int BITS_HI = 64,
  parameter int BITS_LO = 48,
  parameter int MAXC_HI = 4,
  parameter int MAXC_LO = 3
) (
  input  logic              clk_base,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              gate_i,
  input  logic              fam384_i,
  input  logic [CODE_W-1:0] mul_code_i,
  input  logic              bit48_i,
  output logic              mclk_o,
  output logic              mclk_stb_o,
  output logic              bclk_o,
  output logic              bclk_stb_o,
  output logic              fclk_o,
  output logic              fclk_stb_o,
  output logic              cfg_err_o
);
  localparam int PH_W = $clog2(SPAN_HI);

  logic              go, frame_end, mbad, bbad;
  logic [CODE_W-1:0] code_q;
  logic [PH_W:0]     span;
  logic [PH_W-1:0]   bper, phase, bcnt;
  logic [PH_W-1:0]   mmask, mhalf, mval;
  logic [NCLK-1:0]   lvl, stb, ok, ck_q, st_q;
  aosc_cfg_t         live;

  assign go   = run_i & ~gate_i;
  assign live = '{fam384: fam384_i, code: mul_code_i, bit48: bit48_i};

  aosc_cfg_hold #(
    .SPAN_HI(SPAN_HI), .SPAN_LO(SPAN_LO), .BITS_HI(BITS_HI), .BITS_LO(BITS_LO),
    .MAXC_HI(MAXC_HI), .MAXC_LO(MAXC_LO), .PH_W(PH_W)
  ) u_hold (
    .clk(clk_base), .rst_n(rst_n), .go(go), .frame_end(frame_end), .live(live),
    .code_q(code_q), .span(span), .bper(bper), .mbad(mbad), .bbad(bbad)
  );

  aosc_phase_ctr #(.PH_W(PH_W)) u_ctr (
    .clk(clk_base), .rst_n(rst_n), .go(go), .span(span), .bper(bper),
    .phase(phase), .bcnt(bcnt), .frame_end(frame_end)
  );

  // the master clock is a power-of-two slice of the sample phase
  always_comb begin
    mmask = PH_W'((32'd1 << code_q) - 32'd1);
    mhalf = (code_q == '0) ? '0 : PH_W'(32'd1 << (code_q - 1'b1));
    mval  = phase & mmask;
    lvl[IDX_M] = (code_q == '0) | (mval < mhalf);
    stb[IDX_M] = (mval == '0);
    ok[IDX_M]  = ~mbad;
    lvl[IDX_B] = bcnt < (bper >> 1);
    stb[IDX_B] = (bcnt == '0);
    ok[IDX_B]  = ~bbad;
    lvl[IDX_F] = {1'b0, phase} < (span >> 1);
    stb[IDX_F] = (phase == '0);
    ok[IDX_F]  = ~bbad;
  end

  for (genvar i = 0; i < NCLK; i++) begin : g_shape
    aosc_clk_shape u_shape (
      .clk(clk_base), .rst_n(rst_n), .go(go), .ok(ok[i]),
      .lvl(lvl[i]), .stb(stb[i]), .ck_o(ck_q[i]), .stb_o(st_q[i])
    );
  end

  assign mclk_o     = ck_q[IDX_M];
  assign mclk_stb_o = st_q[IDX_M];
  assign bclk_o     = ck_q[IDX_B];
  assign bclk_stb_o = st_q[IDX_B];
  assign fclk_o     = ck_q[IDX_F];
  assign fclk_stb_o = st_q[IDX_F];
  assign cfg_err_o  = mbad | bbad;
endmodule

// File: rtl/aosc_clkgen_chk.sv
module aosc_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic gate,
  input logic mclk,
  input logic mclk_stb,
  input logic bclk,
  input logic bclk_stb,
  input logic fclk,
  input logic fclk_stb,
  input logic cfg_err
);
  p_stop_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && !gate) |=> (!mclk && !bclk && !fclk && !mclk_stb && !bclk_stb && !fclk_stb));

  p_mstb_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_stb |-> mclk);

  p_brise_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> bclk_stb);

  p_frame_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fclk_stb |-> (bclk_stb && bclk && fclk));

  p_frame_mclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fclk_stb && !cfg_err) |-> mclk_stb);

  p_frise_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fclk) |-> fclk_stb);
endmodule

bind aosc_clkgen aosc_clkgen_chk u_chk (
  .clk(clk_base), .rst_n(rst_n), .run(run_i), .gate(gate_i),
  .mclk(mclk_o), .mclk_stb(mclk_stb_o), .bclk(bclk_o), .bclk_stb(bclk_stb_o),
  .fclk(fclk_o), .fclk_stb(fclk_stb_o), .cfg_err(cfg_err_o)
);

// File: tb/tb_aosc_clkgen.sv
`timescale 1ns/1ps
module tb_aosc_clkgen;
  logic clk_base = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0, gate_i = 1'b0, fam384_i = 1'b0, bit48_i = 1'b0;
  logic [2:0] mul_code_i = '0;
  logic mclk_o, mclk_stb_o, bclk_o, bclk_stb_o, fclk_o, fclk_stb_o, cfg_err_o;

  int checks = 0, errors = 0;
  int m_fam, m_code, m_b48, m_ph, p_fam, p_code, p_b48;

  always #10 clk_base = ~clk_base;

  aosc_clkgen dut (
    .clk_base(clk_base), .rst_n(rst_n), .run_i(run_i), .gate_i(gate_i),
    .fam384_i(fam384_i), .mul_code_i(mul_code_i), .bit48_i(bit48_i),
    .mclk_o(mclk_o), .mclk_stb_o(mclk_stb_o), .bclk_o(bclk_o), .bclk_stb_o(bclk_stb_o),
    .fclk_o(fclk_o), .fclk_stb_o(fclk_stb_o), .cfg_err_o(cfg_err_o)
  );

  function automatic int span_of(int fam);
    return fam != 0 ? 384 : 512;
  endfunction
  function automatic bit m_bad(int fam, int code);
    return fam != 0 ? code > 3 : code > 4;
  endfunction
  function automatic bit b_bad(int fam, int b48);
    return fam == 0 && b48 != 0;
  endfunction

  // expected {mclk, mstb, bclk, bstb, fclk, fstb} at sample phase ph
  function automatic logic [5:0] exp_out(int fam, int code, int b48, int ph);
    int sp, bp, mp, r;
    logic [5:0] e;
    sp = span_of(fam);
    bp = sp / (b48 != 0 ? 48 : 64);
    mp = 1 << code;
    e = '0;
    if (!m_bad(fam, code)) begin
      r = ph % mp;
      e[5] = (code == 0) ? 1'b1 : (r < mp / 2);
      e[4] = (r == 0);
    end
    if (!b_bad(fam, b48)) begin
      e[3] = (ph % bp) < bp / 2;
      e[2] = (ph % bp) == 0;
      e[1] = ph < sp / 2;
      e[0] = ph == 0;
    end
    return e;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 30)
        $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive_cfg(int fam, int code, int b48);
    fam384_i = fam[0]; mul_code_i = code[2:0]; bit48_i = b48[0];
  endtask

  task automatic check_quiet(string req);
    chk({mclk_o, mclk_stb_o, bclk_o, bclk_stb_o, fclk_o, fclk_stb_o} == 6'd0, req,
        "outputs while stopped",
        int'({mclk_o, mclk_stb_o, bclk_o, bclk_stb_o, fclk_o, fclk_stb_o}), 0);
  endtask

  // called at a negedge: the next edge samples go=1 with phase 0
  task automatic start_run();
    run_i = 1'b1; gate_i = 1'b0;
    m_fam = fam384_i; m_code = mul_code_i; m_b48 = bit48_i; m_ph = 0;
    @(negedge clk_base);
  endtask

  task automatic run_cycles(int n, string tag, int chg_at, int cf, int cc, int cb);
    for (int t = 0; t < n; t++) begin
      logic [5:0] e;
      int sp;
      bit eerr;
      string rm, rb, rf, re;
      sp = span_of(m_fam);
      e = exp_out(m_fam, m_code, m_b48, m_ph);
      if (m_ph == sp - 1)
        eerr = m_bad(fam384_i, mul_code_i) | b_bad(fam384_i, bit48_i);
      else
        eerr = m_bad(m_fam, m_code) | b_bad(m_fam, m_b48);
      rm = m_bad(m_fam, m_code) ? "R5" : "R2";
      rb = b_bad(m_fam, m_b48) ? "R6" : "R3";
      rf = b_bad(m_fam, m_b48) ? "R6" : "R4";
      re = "R5_R6";
      if (tag != "") begin rm = tag; rb = tag; rf = tag; re = tag; end
      if (t == 0) begin rm = "R1"; rb = "R1"; rf = "R1"; end
      chk(mclk_o == e[5], rm, "mclk", mclk_o, e[5]);
      chk(mclk_stb_o == e[4], rm, "mclk strobe", mclk_stb_o, e[4]);
      chk(bclk_o == e[3], rb, "bclk", bclk_o, e[3]);
      chk(bclk_stb_o == e[2], rb, "bclk strobe", bclk_stb_o, e[2]);
      chk(fclk_o == e[1], rf, "fclk", fclk_o, e[1]);
      chk(fclk_stb_o == e[0], rf, "fclk strobe", fclk_stb_o, e[0]);
      chk(cfg_err_o == eerr, re, "cfg_err", cfg_err_o, eerr);
      if (m_ph == sp - 1) begin
        p_fam = fam384_i; p_code = mul_code_i; p_b48 = bit48_i;
      end
      if (t == chg_at) drive_cfg(cf, cc, cb);
      if (m_ph == sp - 1) begin
        m_ph = 0; m_fam = p_fam; m_code = p_code; m_b48 = p_b48;
      end else begin
        m_ph++;
      end
      @(negedge clk_base);
    end
  endtask

  task automatic stop_run();
    run_i = 1'b0;
    @(negedge clk_base);
    check_quiet("R1");
  endtask

  initial begin
    #3_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_base);
    check_quiet("R1");
    chk(cfg_err_o == 1'b0, "R1", "cfg_err in reset", cfg_err_o, 0);
    rst_n = 1'b1;
    @(negedge clk_base);
    check_quiet("R1");

    // sweep every family, bit-rate and code setting
    for (int fam = 0; fam < 2; fam++) begin
      for (int b48 = 0; b48 < 2; b48++) begin
        for (int code = 0; code < 8; code++) begin
          drive_cfg(fam, code, b48);
          @(negedge clk_base);
          chk(cfg_err_o == (m_bad(fam, code) | b_bad(fam, b48)), "R8", "cfg_err while stopped",
              cfg_err_o, m_bad(fam, code) | b_bad(fam, b48));
          check_quiet("R1");
          start_run();
          run_cycles(2 * span_of(fam) + 3, "", -1, 0, 0, 0);
          stop_run();
        end
      end
    end

    // gate stops everything; clearing it restarts at phase 0
    drive_cfg(0, 2, 0);
    @(negedge clk_base);
    start_run();
    run_cycles(40, "", -1, 0, 0, 0);
    gate_i = 1'b1;
    @(negedge clk_base);
    check_quiet("R1");
    @(negedge clk_base);
    check_quiet("R1");
    start_run();
    run_cycles(600, "", -1, 0, 0, 0);
    stop_run();

    // R7: mid-sample change, change one cycle before the wrap edge, change just after it
    drive_cfg(0, 1, 0);
    @(negedge clk_base);
    start_run();
    run_cycles(1600, "R7", 100, 0, 3, 0);
    stop_run();
    drive_cfg(0, 1, 0);
    @(negedge clk_base);
    start_run();
    run_cycles(1400, "R7", 510, 1, 2, 1);
    stop_run();
    drive_cfg(0, 1, 0);
    @(negedge clk_base);
    start_run();
    run_cycles(1600, "R7", 511, 0, 4, 0);
    stop_run();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule